// File: doc/BRIEF.md
# Two-Order Mesh Route Selector

This block computes the outgoing direction for flits crossing one router of a two-dimensional mesh. It compares the destination coordinates carried by a head flit with the router's own coordinates. It decides whether the packet travels along X first or along Y first, and it names the output port to use. Each of the two orderings is bound to its own virtual channel, so mixing the orderings in one network cannot create a cyclic channel dependency.

The ordering can be fixed to X-first, fixed to Y-first, or alternated packet by packet. It can also be derived from the low bit of source ID XOR destination ID, or read from a small bit table indexed by destination that software or a boot engine fills through a write port. The decision is made once, on the head flit. Every following flit of the packet leaves on the same port and channel. The result appears one clock after the flit is presented.

Top module: `toggle_route_unit`

## Requirements
- R1: After synchronous reset `out_valid` is 0, the alternating-order state is set so that the next alternating packet goes X-first, and every entry of the destination bit table holds 0 (X-first).
- R2: Every cycle with `in_valid` high produces exactly one result with `out_valid` high on the following cycle; cycles without `in_valid` produce none.
- R3: With mode 0 (X-first), a head flit is sent along X while its X coordinate differs from the local one: East (`out_port` bit 2) when larger, West (bit 3) when smaller. Once X matches it goes North (bit 0) when the Y coordinate is larger and South (bit 1) when it is smaller. The channel is 0.
- R4: With mode 1 (Y-first), a head flit is sent along Y first with the same Y directions, then along X once Y matches. The channel is 1.
- R5: A head flit whose destination equals the local coordinates leaves on the Local port (`out_port` bit 4) in every mode.
- R6: With mode 2 (alternating), successive head flits in this mode take X-first, Y-first, X-first, ... starting X-first after reset. Head flits in other modes and non-head flits do not advance the alternation.
- R7: With mode 3, the ordering is bit 0 of `src_id ^ {dest_y, dest_x}`: 0 gives X-first, 1 gives Y-first.
- R8: With mode 4, the ordering is the table entry at index `{dest_y, dest_x}` (0 X-first, 1 Y-first). A write in the same cycle as a head flit is seen only by later head flits.
- R9: A non-head flit leaves on the port and channel chosen by the most recent head flit, whatever its own destination, source or mode inputs carry.
- R10: `out_port` is one-hot whenever `out_valid` is high, and the channel is 0 exactly for X-first packets and 1 for Y-first packets.
- R11: Mode values 5, 6 and 7 route X-first on channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| local_x | input | X_W | X coordinate of this router |
| local_y | input | Y_W | Y coordinate of this router |
| in_valid | input | 1 | A flit is present this cycle |
| in_head | input | 1 | The present flit is a head flit |
| dest_x | input | X_W | Destination X coordinate (head flit) |
| dest_y | input | Y_W | Destination Y coordinate (head flit) |
| src_id | input | X_W+Y_W | Source node ID, packed as {y, x} |
| mode | input | 3 | Ordering mode, 0..4 as in R3-R8 |
| tbl_we | input | 1 | Write enable for the destination bit table |
| tbl_addr | input | X_W+Y_W | Table index, packed as {y, x} |
| tbl_data | input | 1 | Table bit to write (1 = Y-first) |
| out_valid | output | 1 | Result valid, one cycle after the flit |
| out_port | output | 5 | One-hot port: bit0 N, bit1 S, bit2 E, bit3 W, bit4 Local |
| out_vc | output | 1 | Virtual channel: 0 X-first, 1 Y-first |

## Verification
Destinations in every quadrant and on both axes around a fixed router position are routed in the two fixed modes. X-first and Y-first then give visibly different ports for off-axis targets, while on-axis and local targets agree. The alternating mode is tried with foreign-mode heads and body flits interleaved, which separates a per-head toggle from a per-flit or per-cycle one. Source-XOR and table modes are fed pairs that differ only in the selecting bit. A table write in the same cycle as a head exposes whether the read sees old or new contents. Body flits with deliberately changed destination and mode fields show that the head's choice is held.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int PORT_N     = 0;
    localparam int PORT_S     = 1;
    localparam int PORT_E     = 2;
    localparam int PORT_W     = 3;
    localparam int PORT_L     = 4;
    localparam int PORT_COUNT = 5;

    typedef logic [PORT_COUNT-1:0] port_vec_t;

    typedef enum logic [2:0] {
        MODE_XY     = 3'd0,
        MODE_YX     = 3'd1,
        MODE_TOGGLE = 3'd2,
        MODE_SRCXOR = 3'd3,
        MODE_TABLE  = 3'd4
    } route_mode_e;

    typedef enum logic {
        ORD_XY = 1'b0,
        ORD_YX = 1'b1
    } order_e;

    // One-hot output direction from the axis comparisons and the ordering.
    function automatic port_vec_t pick_port(order_e ord, logic x_ne, logic x_gt,
                                            logic y_ne, logic y_gt);
        port_vec_t p;
        p = '0;
        if (!x_ne && !y_ne) begin
            p[PORT_L] = 1'b1;
        end else if ((ord == ORD_XY && x_ne) || (ord == ORD_YX && !y_ne)) begin
            if (x_gt) p[PORT_E] = 1'b1;
            else      p[PORT_W] = 1'b1;
        end else begin
            if (y_gt) p[PORT_N] = 1'b1;
            else      p[PORT_S] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/route_order_sel.sv
module route_order_sel
    import mesh_route_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            head_fire,
    input  route_mode_e     mode,
    input  logic [ID_W-1:0] src_id,
    input  logic [ID_W-1:0] dst_id,
    input  logic            tbl_we,
    input  logic [ID_W-1:0] tbl_addr,
    input  logic            tbl_data,
    output order_e          order
);

    localparam int DEPTH = 1 << ID_W;

    logic             tog_q;
    logic [DEPTH-1:0] tbl_vec;
    logic [ID_W-1:0]  id_mix;

    // Alternation state advances only on head flits in alternating mode.
    always_ff @(posedge clk) begin
        if (rst)                                   tog_q <= 1'b0;
        else if (head_fire && mode == MODE_TOGGLE) tog_q <= ~tog_q;
    end

    // Per-destination ordering bits, one flop each.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)                                        bit_q <= 1'b0;
            else if (tbl_we && tbl_addr == ID_W'(i))        bit_q <= tbl_data;
        end
        assign tbl_vec[i] = bit_q;
    end

    assign id_mix = src_id ^ dst_id;

    always_comb begin
        case (mode)
            MODE_XY:     order = ORD_XY;
            MODE_YX:     order = ORD_YX;
            MODE_TOGGLE: order = order_e'(tog_q);
            MODE_SRCXOR: order = order_e'(id_mix[0]);
            MODE_TABLE:  order = order_e'(tbl_vec[dst_id]);
            default:     order = ORD_XY;
        endcase
    end

    // R6: alternation never moves without a head flit in alternating mode
    assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(head_fire && mode == MODE_TOGGLE) |=> $stable(tog_q));

endmodule

// File: rtl/route_port_calc.sv
module route_port_calc
    import mesh_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0] local_x,
    input  logic [Y_W-1:0] local_y,
    input  logic [X_W-1:0] dest_x,
    input  logic [Y_W-1:0] dest_y,
    input  order_e         order,
    output port_vec_t      port
);

    logic x_ne, x_gt, y_ne, y_gt;

    always_comb begin
        x_ne = (dest_x != local_x);
        x_gt = (dest_x >  local_x);
        y_ne = (dest_y != local_y);
        y_gt = (dest_y >  local_y);
        port = pick_port(order, x_ne, x_gt, y_ne, y_gt);
    end

endmodule

// File: rtl/route_hold.sv
module route_hold
    import mesh_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_head,
    input  port_vec_t new_port,
    input  order_e    new_order,
    output logic      valid_q,
    output port_vec_t port_q,
    output logic      vc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            port_q  <= port_vec_t'(1 << PORT_L);
            vc_q    <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid && in_head) begin
                port_q <= new_port;
                vc_q   <= (new_order == ORD_YX);
            end
        end
    end

    // R9: non-head flits keep the head's route
    assert_body_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_head) |=> ($stable(port_q) && $stable(vc_q)));

    // R2: one result per presented flit
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> valid_q);

endmodule

// File: rtl/toggle_route_unit.sv
module toggle_route_unit
    import mesh_route_pkg::*;
#(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [X_W-1:0]     local_x,
    input  logic [Y_W-1:0]     local_y,
    input  logic               in_valid,
    input  logic               in_head,
    input  logic [X_W-1:0]     dest_x,
    input  logic [Y_W-1:0]     dest_y,
    input  logic [X_W+Y_W-1:0] src_id,
    input  logic [2:0]         mode,
    input  logic               tbl_we,
    input  logic [X_W+Y_W-1:0] tbl_addr,
    input  logic               tbl_data,
    output logic               out_valid,
    output logic [4:0]         out_port,
    output logic               out_vc
);

    localparam int ID_W = X_W + Y_W;

    logic [ID_W-1:0] dst_id;
    logic            head_fire;
    order_e          order;
    port_vec_t       next_port;
    port_vec_t       port_q;

    assign dst_id    = {dest_y, dest_x};
    assign head_fire = in_valid && in_head;

    route_order_sel #(.ID_W(ID_W)) u_order (
        .clk      (clk),
        .rst      (rst),
        .head_fire(head_fire),
        .mode     (route_mode_e'(mode)),
        .src_id   (src_id),
        .dst_id   (dst_id),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_data (tbl_data),
        .order    (order)
    );

    route_port_calc #(.X_W(X_W), .Y_W(Y_W)) u_calc (
        .local_x(local_x),
        .local_y(local_y),
        .dest_x (dest_x),
        .dest_y (dest_y),
        .order  (order),
        .port   (next_port)
    );

    route_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_head  (in_head),
        .new_port (next_port),
        .new_order(order),
        .valid_q  (out_valid),
        .port_q   (port_q),
        .vc_q     (out_vc)
    );

    assign out_port = port_q;

    // R10: a valid result names exactly one port
    assert_onehot_port_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_port) == 1));

    // R5: a packet addressed here is ejected locally
    assert_local_eject_R5: assert property (@(posedge clk) disable iff (rst)
        (head_fire && dest_x == local_x && dest_y == local_y)
        |=> (out_port == 5'b10000));

    // R3: fixed X-first mode uses channel 0
    assert_xy_channel_R3: assert property (@(posedge clk) disable iff (rst)
        (head_fire && mode == 3'd0) |=> !out_vc);

    // R4: fixed Y-first mode uses channel 1
    assert_yx_channel_R4: assert property (@(posedge clk) disable iff (rst)
        (head_fire && mode == 3'd1) |=> out_vc);

endmodule

// File: tb/test_toggle_route_unit.sv
module test_toggle_route_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int LX = 3;
    localparam int LY = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [XW-1:0]  local_x = XW'(LX);
    logic [YW-1:0]  local_y = YW'(LY);
    logic           in_valid = 1'b0;
    logic           in_head = 1'b0;
    logic [XW-1:0]  dest_x = '0;
    logic [YW-1:0]  dest_y = '0;
    logic [XW+YW-1:0] src_id = '0;
    logic [2:0]     mode = '0;
    logic           tbl_we = 1'b0;
    logic [XW+YW-1:0] tbl_addr = '0;
    logic           tbl_data = 1'b0;
    logic           out_valid;
    logic [4:0]     out_port;
    logic           out_vc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit running = 1'b0;

    logic [4:0] q_port[$];
    logic       q_vc[$];
    string      q_tag[$];

    bit         m_tog = 1'b0;
    bit         m_tbl [64];
    logic [4:0] m_port = 5'b10000;
    bit         m_vc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toggle_route_unit #(.X_W(XW), .Y_W(YW)) i_toggle_route_unit (
        .clk(clk), .rst(rst), .local_x(local_x), .local_y(local_y),
        .in_valid(in_valid), .in_head(in_head), .dest_x(dest_x), .dest_y(dest_y),
        .src_id(src_id), .mode(mode), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc)
    );

    // Expected port from signed offsets: bit0 N, bit1 S, bit2 E, bit3 W, bit4 L
    function automatic logic [4:0] ref_port(bit yfirst, int dx, int dy);
        int ox = dx - LX;
        int oy = dy - LY;
        if (ox == 0 && oy == 0) return 5'b10000;
        if (!yfirst) begin
            if (ox > 0) return 5'b00100;
            if (ox < 0) return 5'b01000;
            return (oy > 0) ? 5'b00001 : 5'b00010;
        end
        if (oy != 0) return (oy > 0) ? 5'b00001 : 5'b00010;
        return (ox > 0) ? 5'b00100 : 5'b01000;
    endfunction

    task automatic send(bit head, int m, int dx, int dy, int src,
                        bit we, int waddr, bit wdata, string tag);
        bit yfirst;
        int did;
        @(negedge clk);
        in_valid = 1'b1;
        in_head  = head;
        mode     = 3'(m);
        dest_x   = XW'(dx);
        dest_y   = YW'(dy);
        src_id   = 6'(src);
        tbl_we   = we;
        tbl_addr = 6'(waddr);
        tbl_data = wdata;
        did = (dy << XW) | dx;
        if (head) begin
            case (m)
                1:       yfirst = 1'b1;
                2:       yfirst = m_tog;
                3:       yfirst = bit'((src ^ did) & 1);
                4:       yfirst = m_tbl[did];
                default: yfirst = 1'b0;
            endcase
            if (m == 2) m_tog = ~m_tog;
            m_port = ref_port(yfirst, dx, dy);
            m_vc   = yfirst;
        end
        if (we) m_tbl[waddr] = wdata;
        q_port.push_back(m_port);
        q_vc.push_back(m_vc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_head  = 1'b0;
            tbl_we   = 1'b0;
        end
    endtask

    task automatic twrite(int addr, bit data);
        @(negedge clk);
        in_valid = 1'b0;
        in_head  = 1'b0;
        tbl_we   = 1'b1;
        tbl_addr = 6'(addr);
        tbl_data = data;
        m_tbl[addr] = data;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (running && !done) begin
            if (out_valid) begin
                checks++;
                if (q_port.size() == 0) begin
                    fails++;
                    $display("FAIL R2: out_valid=1 with nothing expected (actual port %b, expected no result)", out_port);
                end else begin
                    logic [4:0] ep;
                    logic       ev;
                    string      et;
                    ep = q_port.pop_front();
                    ev = q_vc.pop_front();
                    et = q_tag.pop_front();
                    if (out_port !== ep || out_vc !== ev) begin
                        fails++;
                        $display("FAIL %s: port/vc actual %b/%0d expected %b/%0d", et, out_port, out_vc, ep, ev);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_tbl[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid during reset actual %b expected 0", out_valid);
        end
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
        end

        // R3 X-first in all directions
        send(1, 0, 5, 1, 0, 0, 0, 0, "R3 east");
        send(1, 0, 1, 6, 0, 0, 0, 0, "R3 west");
        send(1, 0, 3, 6, 0, 0, 0, 0, "R3 north");
        send(1, 0, 3, 2, 0, 0, 0, 0, "R3 south");
        send(1, 0, 3, 4, 0, 0, 0, 0, "R5 local xy");
        idle(2);
        // R4 Y-first
        send(1, 1, 5, 1, 0, 0, 0, 0, "R4 south first");
        send(1, 1, 1, 6, 0, 0, 0, 0, "R4 north first");
        send(1, 1, 5, 4, 0, 0, 0, 0, "R4 east after y");
        send(1, 1, 3, 4, 0, 0, 0, 0, "R5 local yx");
        // R9 body hold with changed fields
        send(1, 0, 5, 1, 0, 0, 0, 0, "R9 head");
        send(0, 1, 0, 7, 9, 0, 0, 0, "R9 body");
        send(0, 2, 3, 4, 1, 0, 0, 0, "R9 tail");
        idle(1);
        // R6 alternation, R1 starts X-first; other-mode heads and bodies do not advance
        send(1, 2, 5, 6, 0, 0, 0, 0, "R6 first xy");
        send(0, 2, 5, 6, 0, 0, 0, 0, "R6 body");
        send(1, 2, 5, 6, 0, 0, 0, 0, "R6 second yx");
        send(1, 0, 5, 6, 0, 0, 0, 0, "R6 foreign head");
        send(1, 2, 5, 6, 0, 0, 0, 0, "R6 third xy");
        send(1, 2, 5, 6, 0, 0, 0, 0, "R6 fourth yx");
        // R7 source XOR
        send(1, 3, 5, 1, 1, 0, 0, 0, "R7 xor0 xy");
        send(1, 3, 5, 1, 0, 0, 0, 0, "R7 xor1 yx");
        send(1, 3, 5, 1, 8, 0, 0, 0, "R7 high bits ignored");
        // R8 table, R1 cleared entries
        send(1, 4, 6, 1, 0, 0, 0, 0, "R1 table clear");
        twrite(62, 1);
        send(1, 4, 6, 7, 0, 0, 0, 0, "R8 entry set");
        send(1, 4, 0, 0, 0, 1, 0, 1, "R8 same-cycle write old");
        send(1, 4, 0, 0, 0, 0, 0, 0, "R8 written yx");
        twrite(62, 0);
        send(1, 4, 6, 7, 0, 0, 0, 0, "R8 entry cleared");
        // R11 undefined modes
        send(1, 6, 5, 1, 0, 0, 0, 0, "R11 mode6");
        send(1, 7, 1, 2, 0, 0, 0, 0, "R11 mode7");
        // R10 channel/order pairing with same target both ways
        send(1, 1, 1, 2, 0, 0, 0, 0, "R10 yx pair");
        idle(3);

        checks++;
        if (q_port.size() != 0) begin
            fails++;
            $display("FAIL R2: results missing actual %0d pending expected 0", q_port.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule